// File: doc/BRIEF.md
# Charge Safety Timeout Counter

This block keeps the safety time budget of a single-cell charger. It counts one-cycle tick pulses that come from an external timing reference. It raises a sticky timeout flag when the current charge phase has used up its allowance. There are two phases: precharge of a deeply discharged cell, and fast charge. Precharge may last 2^PRE_EXP reference periods and fast charge 2^FAST_EXP periods. With the default exponents of 19 and 22 the precharge allowance is exactly one eighth of the fast-charge allowance. Both phases share one counter.

The charge controller drives the phase select, a count enable and a clear pulse. It pulses clear at power-up, at the start of every new charge cycle and whenever a recharge begins. A board strap turns the whole timer off. Time spent in precharge is never charged against the fast-charge budget, because the counter restarts whenever the phase select changes. All pins are plain control and status levels. There is no data stream, so there is no handshake.

Top module: `chg_safety_timer`

## Requirements
- R1: In fast phase (phase_fast_i = 1), charge_timeout_o rises after 2^FAST_EXP ticks have been accepted since the last restart. It is seen on the second rising edge after the edge that accepted the final tick, and not after one tick fewer.
- R2: In precharge phase (phase_fast_i = 0), precharge_timeout_o rises after 2^PRE_EXP accepted ticks, with the same timing as R1. The default exponents (22 and 19) give an 8:1 ratio between the two allowances.
- R3: Any change of phase_fast_i restarts the count from zero at that edge, so ticks accepted in precharge do not count toward the fast-charge limit. A phase change does not clear a flag that is already set.
- R4: While timer_off_i is high, the count is held at zero, both timeout outputs are low one cycle later, and no tick can raise them.
- R5: A clear_i pulse zeroes the count and drops both timeout outputs at the next edge, so the next timeout needs a full allowance again.
- R6: After the asynchronous active-low reset, both timeout outputs are low and the count is zero in precharge phase.
- R7: Once a limit is reached, the count saturates and the flag stays high through further ticks and phase changes until clear_i, timer_off_i or reset.
- R8: A tick is accepted only when enable_i is high in the same cycle. With enable_i low, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per timing-reference period |
| enable_i | input | 1 | Allows ticks to advance the count |
| clear_i | input | 1 | Restarts the budget (new cycle or recharge) |
| phase_fast_i | input | 1 | 0 = precharge, 1 = fast charge |
| timer_off_i | input | 1 | Strap that disables all timeouts |
| precharge_timeout_o | output | 1 | Sticky precharge allowance exhausted |
| charge_timeout_o | output | 1 | Sticky fast-charge allowance exhausted |

## Verification
Directed sequences feed exactly one tick fewer than each limit and then the final tick. This separates an off-by-one in either limit and shows the two-edge flag latency. A precharge run followed by a phase switch shows whether precharge ticks leak into the fast budget. Runs with enable low, with the strap set and with clear pulses show the hold, suppress and restart paths. A long random mix of ticks, enables, phase flips, clears and strap pulses is compared every cycle against a bench model of the requirements. It reaches saturation and sticky flags in both phases many times over.

// File: rtl/chg_timer_pkg.sv
package chg_timer_pkg;
  typedef enum logic {
    PH_PRE  = 1'b0,
    PH_FAST = 1'b1
  } chg_phase_e;
endpackage

// File: rtl/chg_phase_tracker.sv
module chg_phase_tracker
  import chg_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chg_phase_e phase_i,
  output chg_phase_e phase_q,
  output logic       restart
);
  // Remember which phase the current count belongs to.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_PRE;
    else        phase_q <= phase_i;
  end

  assign restart = (phase_i != phase_q);

  // R3: after a phase change edge, the tracked phase equals the requested one
  a_r3_phase_follow: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == $past(phase_i)));
endmodule

// File: rtl/chg_tick_counter.sv
module chg_tick_counter
  import chg_timer_pkg::*;
#(
  parameter int CNT_W = 23,
  parameter logic [CNT_W-1:0] FAST_LIM = '0,
  parameter logic [CNT_W-1:0] PRE_LIM  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             step,
  input  chg_phase_e       phase_i,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cur_lim;
  logic             at_cap;

  assign cur_lim = (phase_i == PH_FAST) ? FAST_LIM : PRE_LIM;
  assign at_cap  = (count >= cur_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (zero)            count <= '0;
    else if (step && !at_cap) count <= count + 1'b1;
  end

  // R5/R4/R3: any zero request leaves the count at zero
  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (count == '0));
  // R8: without an accepted tick the count does not move
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !step) |=> $stable(count));
  // R7: saturated count stays put
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && at_cap) |=> $stable(count));
  // R1: never beyond the larger allowance
  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FAST_LIM);
endmodule

// File: rtl/chg_timeout_flags.sv
module chg_timeout_flags
  import chg_timer_pkg::*;
#(
  parameter int CNT_W = 23,
  parameter logic [CNT_W-1:0] FAST_LIM = '0,
  parameter logic [CNT_W-1:0] PRE_LIM  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic [CNT_W-1:0] count,
  input  chg_phase_e       phase_q,
  output logic [1:0]       flags
);
  // flags[0] = precharge, flags[1] = fast charge
  for (genvar g = 0; g < 2; g++) begin : g_flag
    localparam logic [CNT_W-1:0] LIM = (g == 1) ? FAST_LIM : PRE_LIM;
    localparam chg_phase_e       PH  = (g == 1) ? PH_FAST : PH_PRE;
    logic hit;
    assign hit = (phase_q == PH) && (count == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flags[g] <= 1'b0;
      else if (wipe) flags[g] <= 1'b0;
      else if (hit)  flags[g] <= 1'b1;
    end
  end

  // R7: flags are sticky until wiped
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && (flags != 2'b00)) |=> ((flags & $past(flags)) == $past(flags)));
  // R4/R5: a wipe drops both flags
  a_r4_wipe_low: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (flags == 2'b00));
  // R2: precharge flag only rises out of precharge phase
  a_r2_pre_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(phase_q) == PH_PRE));
  // R1: fast flag only rises out of fast phase
  a_r1_fast_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> ($past(phase_q) == PH_FAST));
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
  import chg_timer_pkg::*;
#(
  parameter int FAST_EXP = 22,
  parameter int PRE_EXP  = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic enable_i,
  input  logic clear_i,
  input  logic phase_fast_i,
  input  logic timer_off_i,
  output logic precharge_timeout_o,
  output logic charge_timeout_o
);
  localparam int CNT_W = FAST_EXP + 1;
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(1) << FAST_EXP;
  localparam logic [CNT_W-1:0] PRE_LIM  = CNT_W'(1) << PRE_EXP;

  chg_phase_e       phase_req;
  chg_phase_e       phase_q;
  logic             restart;
  logic             wipe;
  logic             zero;
  logic             step;
  logic [CNT_W-1:0] count;
  logic [1:0]       flags;

  assign phase_req = chg_phase_e'(phase_fast_i);
  assign wipe      = clear_i | timer_off_i;
  assign zero      = wipe | restart;
  assign step      = tick_i & enable_i;

  chg_phase_tracker u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_req),
    .phase_q (phase_q),
    .restart (restart)
  );

  chg_tick_counter #(
    .CNT_W    (CNT_W),
    .FAST_LIM (FAST_LIM),
    .PRE_LIM  (PRE_LIM)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero    (zero),
    .step    (step),
    .phase_i (phase_req),
    .count   (count)
  );

  chg_timeout_flags #(
    .CNT_W    (CNT_W),
    .FAST_LIM (FAST_LIM),
    .PRE_LIM  (PRE_LIM)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .count   (count),
    .phase_q (phase_q),
    .flags   (flags)
  );

  assign precharge_timeout_o = flags[0];
  assign charge_timeout_o    = flags[1];

  // R4: strap keeps both outputs low on the following cycle
  a_r4_strap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    timer_off_i |=> (!precharge_timeout_o && !charge_timeout_o));
  // R5: clear drops both outputs
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!precharge_timeout_o && !charge_timeout_o));
endmodule

// File: tb/chg_safety_timer_tb.sv
`timescale 1ns/1ps
module chg_safety_timer_tb_top;
  localparam int FAST_EXP = 5;
  localparam int PRE_EXP  = 2;
  localparam int FAST_LIM = 1 << FAST_EXP;
  localparam int PRE_LIM  = 1 << PRE_EXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, enable = 1'b0, clear = 1'b0, phase = 1'b0, toff = 1'b0;
  logic pre_to, fast_to;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  chg_safety_timer #(.FAST_EXP(FAST_EXP), .PRE_EXP(PRE_EXP)) dut_i (
    .clk                 (clk),
    .rst_n               (rst_n),
    .tick_i              (tick),
    .enable_i            (enable),
    .clear_i             (clear),
    .phase_fast_i        (phase),
    .timer_off_i         (toff),
    .precharge_timeout_o (pre_to),
    .charge_timeout_o    (fast_to)
  );

  // Reference model built from the requirements
  int m_cnt = 0;
  bit m_pre = 0, m_fast = 0, m_ph = 0;

  function automatic int lim_of(bit ph);
    return ph ? FAST_LIM : PRE_LIM;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_fast = 0; m_ph = 0;
    end else if (toff || clear) begin
      m_cnt = 0; m_pre = 0; m_fast = 0; m_ph = phase;
    end else begin
      if (!m_ph && m_cnt == PRE_LIM)  m_pre  = 1;
      if (m_ph  && m_cnt == FAST_LIM) m_fast = 1;
      if (phase != m_ph) m_cnt = 0;
      else if (enable && tick && m_cnt < lim_of(phase)) m_cnt++;
      m_ph = phase;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R1 fast flag, R2 precharge flag)
  always @(negedge clk) begin
    if (model_on) begin
      check(pre_to == m_pre,   "R2 model precharge_timeout", pre_to,  m_pre);
      check(fast_to == m_fast, "R1 model charge_timeout",    fast_to, m_fast);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // n single-cycle tick pulses, each followed by one idle cycle
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    // R6: reset state
    check(pre_to == 1'b0 && fast_to == 1'b0, "R6 reset outputs", {pre_to, fast_to}, 0);
    rst_n = 1'b1;
    idle(2);
    model_on = 1'b1;
    check(pre_to == 1'b0 && fast_to == 1'b0, "R6 after release", {pre_to, fast_to}, 0);

    // R2: precharge one short, then exact limit
    enable = 1'b1; phase = 1'b0;
    pulses(PRE_LIM - 1); idle(2);
    check(pre_to == 1'b0, "R2 one tick short", pre_to, 0);
    pulses(1);  // flag on second edge after accepting edge: within the idle slot
    idle(1);
    check(pre_to == 1'b1, "R2 precharge limit", pre_to, 1);

    // R7: saturation and stickiness through more ticks and a phase change
    pulses(5);
    check(pre_to == 1'b1, "R7 sticky after extra ticks", pre_to, 1);
    phase = 1'b1; idle(2);
    check(pre_to == 1'b1, "R7 sticky across phase change", pre_to, 1);

    // R5: clear drops the flag
    clear = 1'b1; idle(1); clear = 1'b0;
    check(pre_to == 1'b0 && fast_to == 1'b0, "R5 clear drops flags", {pre_to, fast_to}, 0);

    // R3: precharge ticks not counted toward fast budget
    phase = 1'b0; idle(1);
    pulses(PRE_LIM - 1);
    phase = 1'b1; idle(1);
    pulses(FAST_LIM - 1); idle(2);
    check(fast_to == 1'b0, "R3 precharge time excluded", fast_to, 0);
    pulses(1); idle(1);
    check(fast_to == 1'b1, "R1 fast limit", fast_to, 1);

    // R8: enable low blocks ticks
    clear = 1'b1; idle(1); clear = 1'b0;
    enable = 1'b0;
    pulses(FAST_LIM + 4); idle(2);
    check(fast_to == 1'b0, "R8 ticks ignored while disabled", fast_to, 0);
    enable = 1'b1;
    pulses(FAST_LIM - 1); idle(2);
    check(fast_to == 1'b0, "R8 count held at zero", fast_to, 0);

    // R4: strap suppresses everything
    toff = 1'b1;
    pulses(FAST_LIM + 4); idle(2);
    check(fast_to == 1'b0 && pre_to == 1'b0, "R4 strap suppresses", {pre_to, fast_to}, 0);
    toff = 1'b0; idle(1);
    pulses(FAST_LIM - 1); idle(2);
    check(fast_to == 1'b0, "R4 strap zeroed count", fast_to, 0);
    pulses(1); idle(1);
    check(fast_to == 1'b1, "R1 fast limit after strap", fast_to, 1);
    toff = 1'b1; idle(1); toff = 1'b0;
    check(fast_to == 1'b0, "R4 strap drops flag", fast_to, 0);

    // Random mix compared against the model each cycle
    for (int i = 0; i < 20000; i++) begin
      tick   = ($urandom % 2) == 0;
      enable = ($urandom % 8) != 0;
      clear  = ($urandom % 96) == 0;
      toff   = ($urandom % 160) == 0;
      if (($urandom % 48) == 0) phase = ~phase;
      @(negedge clk);
    end
    tick = 1'b0; clear = 1'b0; toff = 1'b0;
    idle(3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule